// File: doc/BRIEF.md
# Configurable SPI Master Word Shifter

This block is the serial core of an SPI master. A word offered on the transmit input, together with a valid strobe, is sent on MOSI while the word returned on MISO is gathered. At the end of the exchange the received word appears with a one-cycle strobe. A single format word, read when the transmit word is accepted, sets the bit timing and the framing. The timing settings are the clock divisor, the idle clock level, and the edge on which data is sampled. The framing settings are the bit order, a word length of 2 to 16 bits, an optional trailing parity bit of either sense, and an optional idle gap after each word.

The surrounding logic writes a format and a word while `busy_o` is low, then waits for `rx_valid_o`. Chip selects, buffering and any register bus are handled elsewhere. A parameter sets the lowest divisor the block accepts. A request with a format outside the legal range is dropped.

Top module: `spi_word_engine`

## Requirements
- R1: Each bit takes P+1 module clocks, where P is format bits [7:0]. The first clock edge of a bit comes floor((P+1)/2) clocks after the bit period starts, and the second edge ends the period. The first bit period starts on the clock after acceptance.
- R2: A request is dropped with no effect on any output when P is below max(MIN_PRESCALE,1), or when the word length in format bits [12:8] is outside 2..16.
- R3: Format bit 13 sets the SCLK idle level. SCLK sits at that level when no word is being sent and during the gap, and takes the opposite level between the first and second edge of each bit.
- R4: When format bit 14 is 1, the first bit is on MOSI from the clock after acceptance, MISO is sampled on the first edge, and later bits change on the second edge. When bit 14 is 0, each bit is driven on the first edge and MISO is sampled on the second edge.
- R5: When format bit 15 is 1, bit 0 is sent first. When it is 0, bit L-1 is sent first, where L is the word length. Transmit bits at L and above are never sent.
- R6: After the second edge of the last bit, `rx_data_o` holds the received bits right-justified to L with the upper bits zero, whatever the bit order, and `rx_valid_o` is high for exactly that one clock.
- R7: When format bit 16 is 1, one extra bit follows the data. It equals the XOR of the data bits, inverted when format bit 17 (odd sense) is 1.
- R8: At each completion, `par_err_o` is set if parity is enabled and the received parity bit differs from the value computed from the received data, and is cleared otherwise. It holds until the next completion.
- R9: When format bit 18 is 1 and the gap G in format bits [24:19] is nonzero, `busy_o` stays high for G extra clocks after the last edge, and requests in that window are dropped. With G=0 or bit 18 clear there is no gap.
- R10: `busy_o` rises on the clock after acceptance and stays high through the second edge of the last bit, parity included. Requests that arrive while it is high are ignored and do not disturb the word in flight.
- R11: After reset, all outputs are low. MOSI is low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 25 | Format word, read when a request is accepted |
| tx_data_i | input | 16 | Word to transmit |
| tx_valid_i | input | 1 | Transmit request |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| rx_data_o | output | 16 | Received word, right-justified |
| rx_valid_o | output | 1 | One-clock strobe when a word completes |
| busy_o | output | 1 | Word or gap in progress |
| par_err_o | output | 1 | Parity mismatch on the last completed word |

## Verification
The bench uses odd and even bit periods, so the two halves of SCLK are unequal; a design that split the period the wrong way would move the first edge by a clock. It runs LSB-first with a slave word that differs from the transmitted word, which catches a receiver that stores bits in sending order instead of right-justifying them. It injects a corrupted parity bit and then sends a word without parity, which shows whether the error flag is set and later cleared. It also fires requests during a transfer and during the gap, and offers out-of-range formats; a design that accepted any of these would restart or raise `busy_o`.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DW    = 16;
  localparam int PS_W  = 8;
  localparam int LEN_W = 5;
  localparam int GAP_W = 6;
  localparam int FMT_W = GAP_W + 6 + LEN_W + PS_W;

  typedef struct packed {
    logic [GAP_W-1:0] gap;
    logic             gap_en;
    logic             odd;
    logic             par_en;
    logic             lsb;
    logic             ph;
    logic             cpol;
    logic [LEN_W-1:0] len;
    logic [PS_W-1:0]  presc;
  } fmt_t;

  function automatic logic [DW-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < int'(len));
    return m;
  endfunction

  function automatic logic [LEN_W-1:0] bit_pos(input logic [LEN_W-1:0] i,
                                               input logic [LEN_W-1:0] len,
                                               input logic lsb);
    return lsb ? i : LEN_W'(len - i - LEN_W'(1));
  endfunction

  function automatic logic par_bit(input logic [DW-1:0] data, input logic odd);
    return (^data) ^ odd;
  endfunction

  function automatic logic tx_bit(input logic [DW-1:0] data,
                                  input logic [LEN_W-1:0] len,
                                  input logic lsb, input logic odd,
                                  input logic [LEN_W-1:0] i);
    logic [LEN_W-1:0] p;
    p = bit_pos(i, len, lsb);
    if (i == len) return par_bit(data, odd);
    return data[p[3:0]];
  endfunction
endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [PS_W-1:0] presc,
  output logic            lead_o,
  output logic            trail_o
);
  logic [PS_W-1:0] cnt;
  logic [PS_W:0]   half_m1;

  assign half_m1 = ((({1'b0, presc}) + (PS_W+1)'(1)) >> 1) - (PS_W+1)'(1);
  assign lead_o  = run && ({1'b0, cnt} == half_m1);
  assign trail_o = run && (cnt == presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (start)   cnt <= '0;
    else if (run)     cnt <= trail_o ? '0 : cnt + PS_W'(1);
  end

  a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= presc));
  a_r1_edges_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_o && trail_o));
endmodule

// File: rtl/spi_eng_gap.sv
module spi_eng_gap #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] len,
  output logic             active_o
);
  logic [GAP_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left     <= '0;
      active_o <= 1'b0;
    end else if (start) begin
      left     <= len - GAP_W'(1);
      active_o <= 1'b1;
    end else if (active_o) begin
      if (left == '0) active_o <= 1'b0;
      else            left     <= left - GAP_W'(1);
    end
  end

  a_r9_no_restart_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !start);
  a_r9_nonzero_gap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (len != '0));
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_eng_pkg::*;
#(
  parameter int MIN_PRESCALE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [DW-1:0]    tx_data_i,
  input  logic             tx_valid_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_valid_o,
  output logic             busy_o,
  output logic             par_err_o
);
  localparam int FLOOR = (MIN_PRESCALE < 1) ? 1 : MIN_PRESCALE;

  fmt_t             f_in, cfg_q;
  logic             running, gap_active;
  logic [DW-1:0]    txw, rxw, rx_merged, tx_masked;
  logic             rxpar, par_merged;
  logic [LEN_W-1:0] idx, nbits, cap_pos;
  logic             cfg_ok, accept, lead_edge, trail_edge;
  logic             last_bit, word_done, capture, cap_is_par, gap_start;

  assign f_in      = fmt_t'(fmt_i);
  assign cfg_ok    = (int'(f_in.presc) >= FLOOR) && (f_in.len >= LEN_W'(2))
                     && (int'(f_in.len) <= DW);
  assign accept    = tx_valid_i && !running && !gap_active && cfg_ok;
  assign tx_masked = tx_data_i & len_mask(f_in.len);
  assign nbits     = LEN_W'(cfg_q.len + LEN_W'(cfg_q.par_en));
  assign last_bit  = (idx == LEN_W'(nbits - LEN_W'(1)));
  assign word_done = trail_edge && last_bit;
  assign capture   = cfg_q.ph ? lead_edge : trail_edge;
  assign cap_is_par = (idx == cfg_q.len);
  assign cap_pos   = bit_pos(idx, cfg_q.len, cfg_q.lsb);
  assign gap_start = word_done && cfg_q.gap_en && (cfg_q.gap != '0);
  assign busy_o    = running || gap_active;

  always_comb begin
    rx_merged = rxw;
    if (capture && !cap_is_par) rx_merged[cap_pos[3:0]] = miso_i;
  end
  assign par_merged = (capture && cap_is_par) ? miso_i : rxpar;

  spi_eng_timer #(.PS_W(PS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(running),
    .presc(cfg_q.presc), .lead_o(lead_edge), .trail_o(trail_edge)
  );

  spi_eng_gap #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .len(cfg_q.gap),
    .active_o(gap_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; txw <= '0; rxw <= '0; rxpar <= 1'b0; idx <= '0;
      running <= 1'b0; sclk_o <= 1'b0; mosi_o <= 1'b0;
      rx_data_o <= '0; rx_valid_o <= 1'b0; par_err_o <= 1'b0;
    end else begin
      rx_valid_o <= word_done;
      if (accept) begin
        cfg_q   <= f_in;
        txw     <= tx_masked;
        rxw     <= '0;
        rxpar   <= 1'b0;
        idx     <= '0;
        running <= 1'b1;
        sclk_o  <= f_in.cpol;
        mosi_o  <= f_in.ph ? tx_bit(tx_masked, f_in.len, f_in.lsb, f_in.odd, '0) : 1'b0;
      end else if (running) begin
        rxw   <= rx_merged;
        rxpar <= par_merged;
        if (lead_edge) begin
          sclk_o <= ~cfg_q.cpol;
          if (!cfg_q.ph) mosi_o <= tx_bit(txw, cfg_q.len, cfg_q.lsb, cfg_q.odd, idx);
        end
        if (trail_edge) begin
          sclk_o <= cfg_q.cpol;
          idx    <= idx + LEN_W'(1);
          if (last_bit) begin
            running   <= 1'b0;
            mosi_o    <= 1'b0;
            rx_data_o <= rx_merged;
            par_err_o <= cfg_q.par_en && (par_merged != par_bit(rx_merged, cfg_q.odd));
          end else if (cfg_q.ph) begin
            mosi_o <= tx_bit(txw, cfg_q.len, cfg_q.lsb, cfg_q.odd, idx + LEN_W'(1));
          end
        end
      end else if (!gap_active) begin
        sclk_o <= f_in.cpol;
      end
    end
  end

  a_r11_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mosi_o);
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  a_r10_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> busy_o);
  a_r3_gap_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> (sclk_o == cfg_q.cpol) && !mosi_o);
  a_r3_sclk_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && (sclk_o != $past(sclk_o))) |-> $past(lead_edge || trail_edge));
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (idx < nbits));
  a_r8_no_err_without_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !cfg_q.par_en) |-> !par_err_o);
endmodule

// File: tb/spi_word_engine_tb.sv
module spi_word_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] fmt_i = '0;
  logic [15:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        miso_i = 1'b0;
  logic        sclk_o, mosi_o, rx_valid_o, busy_o, par_err_o;
  logic [15:0] rx_data_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  spi_word_engine #(.MIN_PRESCALE(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .tx_data_i(tx_data_i),
    .tx_valid_i(tx_valid_i), .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .busy_o(busy_o),
    .par_err_o(par_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] mkfmt(int p, int len, int cpol, int ph, int lsb,
                                        int pe, int odd, int gen, int g);
    return {g[5:0], gen[0], odd[0], pe[0], lsb[0], ph[0], cpol[0], len[4:0], p[7:0]};
  endfunction

  // One word exchanged against a behavioural slave; every clock compared.
  task automatic run_word(input logic [24:0] f, input logic [15:0] tx,
                          input logic [15:0] slv, input bit flip, input bit poke,
                          input string tag);
    int p, t, h, len, n, g, cpol, ph, lsb, pe, odd, mask, tpar, spar;
    bit txb[17];
    bit misob[17];
    p = f[7:0]; len = f[12:8]; cpol = f[13]; ph = f[14]; lsb = f[15];
    pe = f[16]; odd = f[17]; g = f[18] ? int'(f[24:19]) : 0;
    t = p + 1; h = t / 2; n = len + pe;
    mask = (1 << len) - 1;
    tpar = ($countones(int'(tx) & mask) % 2) ^ odd;
    spar = (($countones(int'(slv) & mask) % 2) ^ odd) ^ int'(flip);
    for (int k = 0; k < len; k++) begin
      int pos;
      pos = lsb ? k : len - 1 - k;
      txb[k] = tx[pos];
      misob[k] = slv[pos];
    end
    txb[len] = tpar[0];
    misob[len] = spar[0];
    @(negedge clk);
    fmt_i = f; tx_data_i = tx; tx_valid_i = 1'b1;
    for (int c = 0; c <= n * t + g; c++) begin
      int es, em;
      @(negedge clk);
      if (c == 0) tx_valid_i = 1'b0;
      if (poke && c == 2) begin tx_valid_i = 1'b1; tx_data_i = ~tx; end
      if (poke && c == 3) tx_valid_i = 1'b0;
      if (poke && g >= 2 && c == n * t) tx_valid_i = 1'b1;
      if (poke && g >= 2 && c == n * t + 1) tx_valid_i = 1'b0;
      miso_i = (c < n * t) ? misob[c / t] : 1'b0;
      es = cpol; em = 0;
      if (c < n * t) begin
        if ((c % t) >= h) es = 1 - cpol;
        if (ph) em = txb[c / t];
        else if (c >= h) em = txb[(c - h) / t];
      end
      chk($sformatf("%s R1 R3 sclk c=%0d", tag, c), sclk_o, es);
      chk($sformatf("%s R4 R5 R7 mosi c=%0d", tag, c), mosi_o, em);
      chk($sformatf("%s R9 R10 busy c=%0d", tag, c), busy_o, (c < n * t + g) ? 1 : 0);
      chk($sformatf("%s R6 rx_valid c=%0d", tag, c), rx_valid_o, (c == n * t) ? 1 : 0);
      if (c == n * t) begin
        chk($sformatf("%s R6 rx_data", tag), rx_data_o, int'(slv) & mask);
        chk($sformatf("%s R8 par_err", tag), par_err_o, pe & int'(flip));
      end
    end
    miso_i = 1'b0;
  endtask

  task automatic reject(input logic [24:0] f, input string tag);
    @(negedge clk);
    fmt_i = f; tx_data_i = 16'hFFFF; tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk($sformatf("%s R2 busy", tag), busy_o, 0);
      chk($sformatf("%s R2 mosi", tag), mosi_o, 0);
      chk($sformatf("%s R2 rx_valid", tag), rx_valid_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset sclk", sclk_o, 0);
    chk("R11 reset mosi", mosi_o, 0);
    chk("R11 reset busy", busy_o, 0);
    chk("R11 reset rx_valid", rx_valid_o, 0);
    chk("R11 reset rx_data", rx_data_o, 0);
    chk("R11 reset par_err", par_err_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_word(mkfmt(3, 8, 0, 1, 0, 0, 0, 0, 0), 16'h00A5, 16'h003C, 0, 0, "msb ph1");
    fmt_i = mkfmt(4, 12, 1, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    run_word(mkfmt(4, 12, 1, 0, 1, 0, 0, 0, 0), 16'hFABC, 16'h0123, 0, 0, "lsb ph0 cpol1");
    run_word(mkfmt(2, 7, 0, 1, 1, 1, 0, 0, 0), 16'h005B, 16'h006E, 0, 0, "even parity");
    run_word(mkfmt(5, 9, 1, 1, 0, 1, 1, 0, 0), 16'h0155, 16'h01C3, 1, 0, "odd parity bad");
    run_word(mkfmt(3, 10, 0, 0, 0, 0, 0, 0, 0), 16'h02F0, 16'h0311, 0, 0, "err cleared");
    run_word(mkfmt(3, 6, 0, 1, 0, 0, 0, 1, 5), 16'h002D, 16'h0017, 0, 1, "gap five poke");
    run_word(mkfmt(3, 5, 1, 0, 1, 1, 1, 1, 0), 16'h0013, 16'h000A, 0, 1, "gap zero");
    run_word(mkfmt(2, 16, 0, 0, 0, 0, 0, 0, 9), 16'hC3A5, 16'h9E17, 0, 0, "gap off len16");
    run_word(mkfmt(255, 2, 1, 1, 1, 1, 0, 0, 0), 16'hFFFE, 16'h0001, 0, 0, "len2 pmax");

    reject(mkfmt(1, 8, 0, 1, 0, 0, 0, 0, 0), "presc below floor");
    reject(mkfmt(0, 8, 0, 0, 0, 0, 0, 0, 0), "presc zero");
    reject(mkfmt(2, 1, 0, 1, 0, 0, 0, 0, 0), "len one");
    reject(mkfmt(2, 17, 0, 1, 0, 0, 0, 0, 0), "len seventeen");
    finish_run();
  end
endmodule